// File: doc/BRIEF.md
# Tagged Block-Read Bus Master

This block is a bus master for a classic WISHBONE-style synchronous bus that only reads. A command port gives it a starting byte address, a number of words to fetch, a byte-lane mask, an address tag and a cycle tag. The master opens a bus cycle, asks for one word per data phase and sends each returned word, with the data tag the slave gave it, to a result port that carries only a valid strobe. It then closes the cycle on its own.

Every bus output comes straight from a register. The master does not need to see an acknowledge ahead of time to keep the bus busy. On the rising edge where it samples the acknowledge high, it captures the data and also loads the address for the following phase. A slave that acknowledges every cycle therefore gets one word per clock. A slave that inserts wait states sees the request held still for as long as it likes.

The controller has two states. `ST_IDLE` means no bus cycle is open. `ST_BEAT` means the cycle and strobe are raised and the master is waiting for an acknowledge. There are three transitions. *accept* goes from `ST_IDLE` to `ST_BEAT` when a command with a non-zero count arrives. *advance* stays in `ST_BEAT` when an acknowledge arrives while more words remain. *finish* goes from `ST_BEAT` to `ST_IDLE` when the last word is acknowledged. A synchronous reset from either state returns the controller to `ST_IDLE`.

Top module: `brd_read_master`

## Requirements
- R1: While `rst` is high at a rising edge, the master leaves that edge with `bus_cycle`, `bus_strobe`, `bus_cycle_tag` (all zero) and `busy` low, `rd_valid` low, and the remaining word count cleared.
- R2: When `cmd_valid` is high in idle with `cmd_beats` non-zero, the next cycle shows `bus_cycle` and `bus_strobe` high, `busy` high, `bus_addr` equal to `cmd_addr`, and `bus_addr_tag`, `bus_lanes` and `bus_cycle_tag` equal to the command's fields.
- R3: While `bus_strobe` is high and `bus_ack` is low, `bus_addr`, `bus_addr_tag`, `bus_lanes` and `bus_strobe` keep their values for any number of cycles.
- R4: On an edge where `bus_ack` is sampled high with words still to fetch, `bus_addr` steps by one word (DATA_W/8 bytes, wrapping modulo 2^ADDR_W), and `bus_strobe` stays high with no idle cycle in between.
- R5: For each acknowledged phase, `rd_valid` is high in the following cycle only. In that cycle `rd_data` and `rd_tag` equal the `bus_rdata` and `bus_data_tag` sampled on the acknowledging edge, and results appear in phase order.
- R6: On the edge that samples the acknowledge of the last requested word, `bus_cycle`, `bus_strobe`, `bus_cycle_tag` and `busy` drop low. Exactly `cmd_beats` words are fetched.
- R7: `cmd_valid` while `busy` is high is ignored: the open cycle's address and word count are unaffected.
- R8: `bus_ack` while `bus_strobe` is low produces no result on `rd_valid`.
- R9: A command with `cmd_beats` equal to zero is ignored and opens no bus cycle.
- R10: `bus_wr_en` is always low, marking every transfer as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken only in idle |
| cmd_addr | input | ADDR_W | Byte address of the first word |
| cmd_beats | input | CNT_W | Number of words to read |
| cmd_lanes | input | DATA_W/8 | Byte-lane mask for every phase |
| cmd_addr_tag | input | ATAG_W | Tag sent with each address |
| cmd_cycle_tag | input | CTAG_W | Tag sent for the whole cycle |
| busy | output | 1 | High from acceptance until the cycle closes |
| bus_addr | output | ADDR_W | Bus address |
| bus_addr_tag | output | ATAG_W | Address tag |
| bus_lanes | output | DATA_W/8 | Byte-lane select |
| bus_wr_en | output | 1 | Write enable, held low |
| bus_cycle | output | 1 | Bus cycle open |
| bus_strobe | output | 1 | Data phase request |
| bus_cycle_tag | output | CTAG_W | Cycle tag, zero outside a cycle |
| bus_ack | input | 1 | Slave acknowledge |
| bus_rdata | input | DATA_W | Read data from slave |
| bus_data_tag | input | DTAG_W | Data tag from slave |
| rd_valid | output | 1 | One-cycle result strobe |
| rd_data | output | DATA_W | Captured word |
| rd_tag | output | DTAG_W | Captured data tag |

## Verification
Block reads run against a slave that acknowledges every cycle, so zero-wait back-to-back phases show that the address advances on the same edge as the capture. Other runs add wait states on alternate phases, which separates holding the request still from advancing it. Single-word reads and reads whose address crosses the top of the address space test the closing edge and the address wrap. Directed cases send commands while busy, commands with a zero count, stray acknowledges in idle and a reset in the middle of a cycle. These show that each of those inputs leaves the bus and the result port untouched.

// File: rtl/brd_pkg.sv
package brd_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BEAT = 1'b1
    } brd_state_e;
endpackage

// File: rtl/brd_beat_counter.sv
module brd_beat_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_val;
        end else if (dec) begin
            remain_q <= remain_q - ONE;
        end
    end

    assign last = (remain_q == ONE);

    // R6: a decrement never arrives with nothing left to fetch
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
        dec |-> (remain_q != '0));
endmodule

// File: rtl/brd_addr_gen.sv
module brd_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              advance,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] INC = ADDR_W'(STEP);

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= load_addr;
        end else if (advance) begin
            addr_q <= addr_q + INC;
        end
    end

    assign addr = addr_q;

    // R7: load and advance are never requested together
    a_r7_load_excl: assert property (@(posedge clk) disable iff (rst)
        !(load && advance));
endmodule

// File: rtl/brd_capture.sv
module brd_capture #(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [DATA_W-1:0] din,
    input  logic [TAG_W-1:0]  tin,
    output logic              valid,
    output logic [DATA_W-1:0] data,
    output logic [TAG_W-1:0]  tag
);
    logic              valid_q;
    logic [DATA_W-1:0] data_q;
    logic [TAG_W-1:0]  tag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= take;
        end
    end

    always_ff @(posedge clk) begin
        if (take) begin
            data_q <= din;
            tag_q  <= tin;
        end
    end

    assign valid = valid_q;
    assign data  = data_q;
    assign tag   = tag_q;
endmodule

// File: rtl/brd_ctrl.sv
module brd_ctrl
    import brd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmd_valid,
    input  logic cmd_nonzero,
    input  logic ack,
    input  logic last,
    output logic accept,
    output logic advance,
    output logic take,
    output logic finish,
    output logic cyc,
    output logic stb
);
    brd_state_e state_q, state_d;
    logic       cyc_q, stb_q;
    logic       beat_ack;

    assign beat_ack = (state_q == ST_BEAT) && ack;
    assign accept   = (state_q == ST_IDLE) && cmd_valid && cmd_nonzero;
    assign advance  = beat_ack && !last;
    assign finish   = beat_ack && last;
    assign take     = beat_ack;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_BEAT;
            ST_BEAT: if (finish) state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // registered bus controls
    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q <= 1'b0;
            stb_q <= 1'b0;
        end else begin
            cyc_q <= (state_d == ST_BEAT);
            stb_q <= (state_d == ST_BEAT);
        end
    end

    assign cyc = cyc_q;
    assign stb = stb_q;

    // R6: leaving the beat state happens only on an acknowledge
    a_r6_leave_on_ack: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BEAT && !ack) |=> (state_q == ST_BEAT));
endmodule

// File: rtl/brd_read_master.sv
module brd_read_master #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8,
    parameter int ATAG_W = 4,
    parameter int CTAG_W = 4,
    parameter int DTAG_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  logic [ADDR_W-1:0]   cmd_addr,
    input  logic [CNT_W-1:0]    cmd_beats,
    input  logic [DATA_W/8-1:0] cmd_lanes,
    input  logic [ATAG_W-1:0]   cmd_addr_tag,
    input  logic [CTAG_W-1:0]   cmd_cycle_tag,
    output logic                busy,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [ATAG_W-1:0]   bus_addr_tag,
    output logic [DATA_W/8-1:0] bus_lanes,
    output logic                bus_wr_en,
    output logic                bus_cycle,
    output logic                bus_strobe,
    output logic [CTAG_W-1:0]   bus_cycle_tag,
    input  logic                bus_ack,
    input  logic [DATA_W-1:0]   bus_rdata,
    input  logic [DTAG_W-1:0]   bus_data_tag,
    output logic                rd_valid,
    output logic [DATA_W-1:0]   rd_data,
    output logic [DTAG_W-1:0]   rd_tag
);
    localparam int LANES = DATA_W / 8;
    localparam int STEP  = LANES;

    logic accept, advance, take, finish, last;
    logic cyc, stb;

    logic [LANES-1:0]  lanes_q;
    logic [ATAG_W-1:0] atag_q;
    logic [CTAG_W-1:0] ctag_q;

    brd_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_nonzero(cmd_beats != '0),
        .ack        (bus_ack),
        .last       (last),
        .accept     (accept),
        .advance    (advance),
        .take       (take),
        .finish     (finish),
        .cyc        (cyc),
        .stb        (stb)
    );

    brd_beat_counter #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .load_val(cmd_beats),
        .dec     (take),
        .last    (last)
    );

    brd_addr_gen #(.ADDR_W(ADDR_W), .STEP(STEP)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_addr(cmd_addr),
        .advance  (advance),
        .addr     (bus_addr)
    );

    brd_capture #(.DATA_W(DATA_W), .TAG_W(DTAG_W)) u_cap (
        .clk  (clk),
        .rst  (rst),
        .take (take),
        .din  (bus_rdata),
        .tin  (bus_data_tag),
        .valid(rd_valid),
        .data (rd_data),
        .tag  (rd_tag)
    );

    // per-phase lane and address tag, reloaded with the command
    always_ff @(posedge clk) begin
        if (rst) begin
            lanes_q <= '0;
            atag_q  <= '0;
        end else if (accept) begin
            lanes_q <= cmd_lanes;
            atag_q  <= cmd_addr_tag;
        end
    end

    // cycle tag lives only while the cycle is open
    always_ff @(posedge clk) begin
        if (rst) begin
            ctag_q <= '0;
        end else if (accept) begin
            ctag_q <= cmd_cycle_tag;
        end else if (finish) begin
            ctag_q <= '0;
        end
    end

    assign bus_lanes     = lanes_q;
    assign bus_addr_tag  = atag_q;
    assign bus_cycle_tag = ctag_q;
    assign bus_cycle     = cyc;
    assign bus_strobe    = stb;
    assign busy          = cyc;
    assign bus_wr_en     = 1'b0;

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!bus_cycle && !bus_strobe && !busy && !rd_valid));

    a_r2_open_cycle: assert property (@(posedge clk) disable iff (rst)
        (!bus_cycle && cmd_valid && cmd_beats != '0) |=>
            (bus_cycle && bus_strobe && bus_addr == $past(cmd_addr)
             && bus_cycle_tag == $past(cmd_cycle_tag)));

    a_r3_hold_wait: assert property (@(posedge clk) disable iff (rst)
        (bus_strobe && !bus_ack) |=>
            (bus_strobe && $stable(bus_addr) && $stable(bus_lanes)
             && $stable(bus_addr_tag)));

    a_r4_step_addr: assert property (@(posedge clk) disable iff (rst)
        (bus_strobe && bus_ack) |=>
            (!bus_cycle || (bus_strobe
             && bus_addr == $past(bus_addr) + ADDR_W'(STEP))));

    a_r5_capture: assert property (@(posedge clk) disable iff (rst)
        (bus_strobe && bus_ack) |=>
            (rd_valid && rd_data == $past(bus_rdata)
             && rd_tag == $past(bus_data_tag)));

    a_r6_close_on_ack: assert property (@(posedge clk) disable iff (rst)
        ($fell(bus_cycle) && !$past(rst)) |-> $past(bus_ack));

    a_r8_no_stray: assert property (@(posedge clk) disable iff (rst)
        !(bus_strobe && bus_ack) |=> !rd_valid);

    a_r9_zero_count: assert property (@(posedge clk) disable iff (rst)
        (!bus_cycle && cmd_valid && cmd_beats == '0) |=> !bus_cycle);
endmodule

// File: tb/brd_read_master_tb.sv
module brd_read_master_tb;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int NV = 5;
    localparam logic [31:0] MASK = 32'h5A5A_0F0F;

    typedef struct packed {
        logic [31:0] addr;
        logic [7:0]  beats;
        logic [3:0]  lanes;
        logic [3:0]  atag;
        logic [3:0]  ctag;
        logic [3:0]  wt;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{32'h0000_1000, 8'd4, 4'hF, 4'h1, 4'h2, 4'd0},
        '{32'h0000_2040, 8'd3, 4'h3, 4'h5, 4'h6, 4'd2},
        '{32'h0000_FFF8, 8'd1, 4'hC, 4'hA, 4'hB, 4'd3},
        '{32'h8000_0000, 8'd6, 4'hF, 4'h7, 4'h9, 4'd1},
        '{32'hFFFF_FFF8, 8'd3, 4'hF, 4'h2, 4'h4, 4'd1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [7:0] cmd_beats = '0;
    logic [3:0] cmd_lanes = '0, cmd_addr_tag = '0, cmd_cycle_tag = '0;
    logic busy, bus_wr_en, bus_cycle, bus_strobe, rd_valid;
    logic [AW-1:0] bus_addr;
    logic [3:0] bus_addr_tag, bus_lanes, bus_cycle_tag, rd_tag;
    logic bus_ack = 1'b0;
    logic [DW-1:0] bus_rdata = '0;
    logic [3:0] bus_data_tag = '0;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    brd_read_master u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
        .cmd_beats(cmd_beats), .cmd_lanes(cmd_lanes),
        .cmd_addr_tag(cmd_addr_tag), .cmd_cycle_tag(cmd_cycle_tag),
        .busy(busy), .bus_addr(bus_addr), .bus_addr_tag(bus_addr_tag),
        .bus_lanes(bus_lanes), .bus_wr_en(bus_wr_en), .bus_cycle(bus_cycle),
        .bus_strobe(bus_strobe), .bus_cycle_tag(bus_cycle_tag),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_data_tag(bus_data_tag),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_tag(rd_tag)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] a, input logic [7:0] n,
                         input logic [3:0] ln, at, ct);
        @(negedge clk);
        cmd_addr = a; cmd_beats = n; cmd_lanes = ln;
        cmd_addr_tag = at; cmd_cycle_tag = ct; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // acknowledge one phase and check the capture one cycle later
    task automatic ack_beat(input logic [31:0] ea, input bit is_last);
        bus_ack = 1'b1;
        bus_rdata = ea ^ MASK;
        bus_data_tag = ea[5:2] ^ 4'h3;
        @(negedge clk);
        bus_ack = 1'b0;
        check(rd_valid && rd_data == (ea ^ MASK), "R5 data", {32'd0, rd_data}, {32'd0, ea ^ MASK});
        check(rd_tag == (ea[5:2] ^ 4'h3), "R5 tag", 64'(rd_tag), 64'(ea[5:2] ^ 4'h3));
        if (is_last)
            check(!bus_cycle && !bus_strobe && !busy && bus_cycle_tag == 4'h0,
                  "R6 close", {bus_cycle, bus_strobe, busy}, 64'd0);
        else
            check(bus_cycle && bus_strobe, "R4 no turnaround", {bus_cycle, bus_strobe}, 64'd3);
    endtask

    task automatic run_read(input vec_t v);
        issue(v.addr, v.beats, v.lanes, v.atag, v.ctag);
        check(bus_cycle && bus_strobe && busy, "R2 open", {bus_cycle, bus_strobe, busy}, 64'd7);
        check(bus_addr == v.addr && bus_lanes == v.lanes && bus_addr_tag == v.atag
              && bus_cycle_tag == v.ctag, "R2 fields", {32'd0, bus_addr}, {32'd0, v.addr});
        check(!bus_wr_en, "R10 read only", 64'(bus_wr_en), 64'd0);
        for (int i = 0; i < int'(v.beats); i++) begin
            logic [31:0] ea;
            int wi;
            ea = v.addr + 32'(i * 4);
            wi = (i % 2 == 1) ? int'(v.wt) : 0;
            check(bus_addr == ea, "R4 address", {32'd0, bus_addr}, {32'd0, ea});
            for (int k = 0; k < wi; k++) begin
                @(negedge clk);
                check(bus_strobe && bus_addr == ea && bus_lanes == v.lanes
                      && bus_addr_tag == v.atag, "R3 hold", {32'd0, bus_addr}, {32'd0, ea});
                if (k == 0) check(!rd_valid, "R5 one cycle", 64'(rd_valid), 64'd0);
            end
            ack_beat(ea, i == int'(v.beats) - 1);
        end
        @(negedge clk);
        check(!rd_valid && !bus_cycle, "R6 stays closed", {rd_valid, bus_cycle}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!bus_cycle && !bus_strobe && !busy && !rd_valid && bus_cycle_tag == 4'h0,
              "R1 reset", {bus_cycle, bus_strobe, busy, rd_valid}, 64'd0);
        rst = 1'b0;

        for (int j = 0; j < NV; j++) run_read(VECS[j]);

        // R7: command while busy is ignored
        issue(32'h0000_0300, 8'd2, 4'hF, 4'h1, 4'h1);
        cmd_addr = 32'h0000_0900; cmd_beats = 8'd5; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(bus_addr == 32'h300, "R7 address kept", {32'd0, bus_addr}, 64'h300);
        ack_beat(32'h0000_0300, 1'b0);
        ack_beat(32'h0000_0304, 1'b1);
        check(!bus_cycle, "R7 count kept", 64'(bus_cycle), 64'd0);

        // R8: stray acknowledge in idle
        @(negedge clk);
        bus_ack = 1'b1;
        @(negedge clk);
        bus_ack = 1'b0;
        check(!rd_valid && !bus_cycle, "R8 stray ack", {rd_valid, bus_cycle}, 64'd0);

        // R9: zero-count command
        issue(32'h0000_0400, 8'd0, 4'hF, 4'h1, 4'h1);
        check(!bus_cycle && !busy, "R9 zero count", {bus_cycle, busy}, 64'd0);
        @(negedge clk);
        check(!bus_cycle && !rd_valid, "R9 still idle", {bus_cycle, rd_valid}, 64'd0);

        // R1: reset in the middle of a cycle
        issue(32'h0000_0500, 8'd4, 4'hF, 4'h2, 4'h3);
        rst = 1'b1;
        @(negedge clk);
        check(!bus_cycle && !bus_strobe && !busy && bus_cycle_tag == 4'h0,
              "R1 mid-cycle reset", {bus_cycle, bus_strobe, busy}, 64'd0);
        rst = 1'b0;
        run_read('{32'h0000_0600, 8'd2, 4'h1, 4'h3, 4'h5, 4'd1});

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule